// File: doc/BRIEF.md
# Zero-Voltage Commutation Sequencer for a Pinched DC Link

This block sits between a PWM pattern generator and the gate drivers of a three-level inverter that has two mirrored resonant banks on its DC link, one on the positive rail and one on the negative rail. It compares the incoming main-switch gating pattern with the one now applied to the bridge. When they differ, it withholds the new pattern and runs a timed sequence on each bank. The bus clamp opens first, the auxiliary switch then starts a half resonant swing of the bus towards neutral, a zero-voltage window follows, and the bank recharges before the clamp closes again.

The new pattern reaches the main switches on the first cycle of the zero-voltage window and at no other time. The positive bank is triggered first. The negative bank follows after a fixed alignment delay and uses a shorter half period, so both rails reach neutral on the same cycle. If the pattern changes while a sequence is running, the latest differing pattern is held. It is serviced on the first rest cycle after the sequence ends.

All timing is in clock cycles. It is set by parameters: the positive-bank half period T_HALF, the alignment delay T_ALIGN (with 1 <= T_ALIGN < T_HALF), the zero window T_ZERO and the recharge length T_RECHG, each at least 1.

Top module: `zvs_commutation_seq`

## Requirements
- R1: A sequence starts from a rest cycle in which `pat_in` differs from `main_pat` in any bit, provided no change is pending. `clamp_pos` goes low in the next cycle. That cycle is called k=1, and k counts cycles from there on.
- R2: After reset, and at rest, both clamp outputs are 1, both auxiliary outputs are 0 and `main_pat` is all zeros. A `pat_in` equal to `main_pat` starts nothing.
- R3: The clamp of each bank is low for at least one cycle before that bank's auxiliary output goes high. The positive auxiliary output is high from k=2.
- R4: The positive auxiliary output stays high for exactly T_HALF+T_ZERO cycles, covering k=2 to k=1+T_HALF+T_ZERO.
- R5: `main_pat` takes the new pattern at k=2+T_HALF, which is the first zero-window cycle. At every other time it holds its value.
- R6: After the auxiliary outputs fall, clamp and auxiliary outputs are both low for T_RECHG cycles. Both clamps return high at k=2+T_HALF+T_ZERO+T_RECHG, and that cycle is a rest cycle.
- R7: The negative bank lags the positive bank by T_ALIGN cycles. Its clamp goes low at k=1+T_ALIGN and its auxiliary output is high from k=2+T_ALIGN. Its auxiliary output falls in the same cycle as the positive one.
- R8: A `pat_in` that differs from the target of the running sequence is kept as pending, and a later differing value replaces it. The pending pattern starts a new sequence on the first rest cycle, whatever `pat_in` is in that cycle.
- R9: In each bank the clamp output and the auxiliary output are never high in the same cycle.
- R10: A synchronous active-high reset in the middle of a sequence returns all outputs to the rest state of R2 in the next cycle, and drops any pending pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_in | input | PAT_W | Gating pattern requested by the PWM generator |
| clamp_pos | output | 1 | Positive-rail bus clamp gate |
| clamp_neg | output | 1 | Negative-rail bus clamp gate |
| aux_pos | output | 1 | Positive-rail resonance auxiliary gate |
| aux_neg | output | 1 | Negative-rail resonance auxiliary gate |
| main_pat | output | PAT_W | Pattern applied to the main bridge switches |

## Verification
Each bank's cycle counter and stage show directly on its gate outputs. A stage or count that is off by one moves an edge of `clamp_*` or `aux_*` by a cycle, and the comparison at the first cycle of that sequence catches it. A wrong target or pending register appears only at `main_pat` in the zero window. That can be as late as one full sequence after the corrupting input, for a pending pattern. Misalignment between the banks shows as the two auxiliary outputs falling on different cycles.

// File: rtl/zvs_pkg.sv
package zvs_pkg;

    typedef enum logic [2:0] {
        BK_REST,
        BK_RELEASE,
        BK_RESON,
        BK_ZERO,
        BK_RECHG
    } bank_stage_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_ALIGN,
        CT_RUN
    } ctrl_state_e;

endpackage

// File: rtl/zvs_bank.sv
module zvs_bank
    import zvs_pkg::*;
#(
    parameter int T_HALF  = 10,
    parameter int T_ZERO  = 4,
    parameter int T_RECHG = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic clamp_o,
    output logic aux_o,
    output logic in_zero_o,
    output logic enter_zero_o,
    output logic done_o
);

    localparam int MAX_A = (T_HALF > T_ZERO) ? T_HALF : T_ZERO;
    localparam int MAX_L = (MAX_A > T_RECHG) ? MAX_A : T_RECHG;
    localparam int CNT_W = $clog2(MAX_L + 1);
    localparam int ON_LEN = T_HALF + T_ZERO;
    localparam int LEN_W = $clog2(ON_LEN + 2);

    typedef struct packed {
        bank_stage_e      stage;
        logic [CNT_W-1:0] cnt;
        logic             clamp;
        logic             aux;
    } bank_reg_t;

    bank_reg_t q, d;

    always_comb begin
        d            = q;
        enter_zero_o = 1'b0;
        done_o       = 1'b0;
        case (q.stage)
            BK_REST: begin
                if (trig) begin
                    d.stage = BK_RELEASE;
                end
            end
            BK_RELEASE: begin
                d.stage = BK_RESON;
                d.cnt   = CNT_W'(T_HALF - 1);
            end
            BK_RESON: begin
                if (q.cnt == '0) begin
                    d.stage      = BK_ZERO;
                    d.cnt        = CNT_W'(T_ZERO - 1);
                    enter_zero_o = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            BK_ZERO: begin
                if (q.cnt == '0) begin
                    d.stage = BK_RECHG;
                    d.cnt   = CNT_W'(T_RECHG - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            BK_RECHG: begin
                if (q.cnt == '0) begin
                    d.stage = BK_REST;
                    done_o  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.stage = BK_REST;
        endcase
        d.clamp = (d.stage == BK_REST);
        d.aux   = (d.stage == BK_RESON) || (d.stage == BK_ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.stage <= BK_REST;
            q.cnt   <= '0;
            q.clamp <= 1'b1;
            q.aux   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign clamp_o   = q.clamp;
    assign aux_o     = q.aux;
    assign in_zero_o = (q.stage == BK_ZERO);

    // Checker: length of each auxiliary pulse.
    logic [LEN_W-1:0] alen_q;
    always_ff @(posedge clk) begin
        if (rst)        alen_q <= '0;
        else if (q.aux) alen_q <= alen_q + 1'b1;
        else            alen_q <= '0;
    end

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(q.clamp && q.aux)); // R9
    AST_CLAMP_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(q.aux) |-> !$past(q.clamp)); // R3
    AST_AUX_LEN: assert property (@(posedge clk) disable iff (rst)
        ($fell(q.aux) && !$past(rst)) |-> (alen_q == LEN_W'(ON_LEN))); // R4
    AST_RECHG_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(q.clamp) && !$past(rst)) |-> !$past(q.aux)); // R6

endmodule

// File: rtl/zvs_ctrl.sv
module zvs_ctrl
    import zvs_pkg::*;
#(
    parameter int PAT_W   = 12,
    parameter int T_ALIGN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAT_W-1:0] pat_in,
    input  logic             enter_zero,
    input  logic             run_done,
    output logic             trig_pos,
    output logic             trig_neg,
    output logic [PAT_W-1:0] main_pat,
    output logic             busy
);

    localparam int ACW = $clog2(T_ALIGN + 1);

    typedef struct packed {
        ctrl_state_e      state;
        logic [ACW-1:0]   acnt;
        logic [PAT_W-1:0] target;
        logic [PAT_W-1:0] applied;
        logic [PAT_W-1:0] pend;
        logic             pend_vld;
    } ctrl_reg_t;

    ctrl_reg_t q, d;
    logic      start;

    always_comb begin
        d        = q;
        trig_pos = 1'b0;
        trig_neg = 1'b0;
        start    = 1'b0;
        case (q.state)
            CT_IDLE: begin
                if (q.pend_vld) begin
                    d.target   = q.pend;
                    d.pend_vld = 1'b0;
                    start      = 1'b1;
                end else if (|(pat_in ^ q.applied)) begin
                    d.target = pat_in;
                    start    = 1'b1;
                end
                if (start) begin
                    trig_pos = 1'b1;
                    d.state  = CT_ALIGN;
                    d.acnt   = ACW'(T_ALIGN - 1);
                end
            end
            CT_ALIGN: begin
                if (q.acnt == '0) begin
                    trig_neg = 1'b1;
                    d.state  = CT_RUN;
                end else begin
                    d.acnt = q.acnt - 1'b1;
                end
            end
            CT_RUN: begin
                if (run_done) begin
                    d.state = CT_IDLE;
                end
            end
            default: d.state = CT_IDLE;
        endcase
        if ((q.state != CT_IDLE) && (|(pat_in ^ q.target))) begin
            d.pend     = pat_in;
            d.pend_vld = 1'b1;
        end
        if (enter_zero) begin
            d.applied = q.target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state    <= CT_IDLE;
            q.acnt     <= '0;
            q.target   <= '0;
            q.applied  <= '0;
            q.pend     <= '0;
            q.pend_vld <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign main_pat = q.applied;
    assign busy     = (q.state != CT_IDLE);

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        trig_pos |-> (q.state == CT_IDLE)); // R8
    AST_PEND_SERVED: assert property (@(posedge clk) disable iff (rst)
        ((q.state == CT_IDLE) && q.pend_vld) |=> (busy && !q.pend_vld)); // R8

endmodule

// File: rtl/zvs_commutation_seq.sv
module zvs_commutation_seq
    import zvs_pkg::*;
#(
    parameter int PAT_W   = 12,
    parameter int T_HALF  = 10,
    parameter int T_ALIGN = 3,
    parameter int T_ZERO  = 4,
    parameter int T_RECHG = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAT_W-1:0] pat_in,
    output logic             clamp_pos,
    output logic             clamp_neg,
    output logic             aux_pos,
    output logic             aux_neg,
    output logic [PAT_W-1:0] main_pat
);

    localparam int NBANK = 2;

    logic [NBANK-1:0] trig_w;
    logic [NBANK-1:0] clamp_w;
    logic [NBANK-1:0] aux_w;
    logic [NBANK-1:0] zero_w;
    logic [NBANK-1:0] enter_w;
    logic [NBANK-1:0] done_w;
    logic             trig_pos;
    logic             trig_neg;
    logic             busy;

    zvs_ctrl #(
        .PAT_W   (PAT_W),
        .T_ALIGN (T_ALIGN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pat_in     (pat_in),
        .enter_zero (&enter_w),
        .run_done   (&done_w),
        .trig_pos   (trig_pos),
        .trig_neg   (trig_neg),
        .main_pat   (main_pat),
        .busy       (busy)
    );

    assign trig_w = {trig_neg, trig_pos};

    // Bank 0 is the positive rail, bank 1 the negative rail, started later.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int HALF_B = (b == 0) ? T_HALF : (T_HALF - T_ALIGN);
        zvs_bank #(
            .T_HALF  (HALF_B),
            .T_ZERO  (T_ZERO),
            .T_RECHG (T_RECHG)
        ) u_bank (
            .clk          (clk),
            .rst          (rst),
            .trig         (trig_w[b]),
            .clamp_o      (clamp_w[b]),
            .aux_o        (aux_w[b]),
            .in_zero_o    (zero_w[b]),
            .enter_zero_o (enter_w[b]),
            .done_o       (done_w[b])
        );
    end

    assign clamp_pos = clamp_w[0];
    assign clamp_neg = clamp_w[1];
    assign aux_pos   = aux_w[0];
    assign aux_neg   = aux_w[1];

    AST_BANKS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (zero_w[0] == zero_w[1])); // R7
    AST_APPLY_IN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$stable(main_pat) && !$past(rst)) |-> (zero_w[0] && zero_w[1] && $rose(zero_w[0]))); // R5
    AST_REST_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (clamp_pos && clamp_neg && !aux_pos && !aux_neg)); // R2
    AST_NEG_LAGS: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_neg) |-> !clamp_pos); // R7

endmodule

// File: tb/sim_zvs_commutation_seq.sv
module sim_zvs_commutation_seq;

    localparam int PW  = 12;
    localparam int T0  = 10;
    localparam int A   = 3;
    localparam int TZ  = 4;
    localparam int TR  = 10;
    localparam int L   = 1 + T0 + TZ + TR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] pat_in = '0;
    logic          clamp_pos, clamp_neg, aux_pos, aux_neg;
    logic [PW-1:0] main_pat;

    always #2 clk = ~clk;

    zvs_commutation_seq #(
        .PAT_W(PW), .T_HALF(T0), .T_ALIGN(A), .T_ZERO(TZ), .T_RECHG(TR)
    ) u0 (
        .clk(clk), .rst(rst), .pat_in(pat_in),
        .clamp_pos(clamp_pos), .clamp_neg(clamp_neg),
        .aux_pos(aux_pos), .aux_neg(aux_neg), .main_pat(main_pat)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    // Behavioural reference model
    bit            m_valid = 0;
    bit            m_busy  = 0;
    int            m_k     = 0;
    logic [PW-1:0] m_target = '0, m_applied = '0, m_pend = '0;
    bit            m_pvld  = 0;

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        m_valid = 1;
        if (rst) begin
            m_busy = 0; m_k = 0; m_target = '0; m_applied = '0;
            m_pend = '0; m_pvld = 0;
        end else if (!m_busy) begin
            if (m_pvld) begin
                m_target = m_pend; m_pvld = 0; m_busy = 1; m_k = 1;
            end else if (pat_in != m_applied) begin
                m_target = pat_in; m_busy = 1; m_k = 1;
            end
        end else begin
            if (pat_in != m_target) begin
                m_pend = pat_in; m_pvld = 1;
            end
            m_k++;
            if (m_k == 2 + T0) m_applied = m_target;
            if (m_k > L) m_busy = 0;
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (m_valid && !ended) begin
            check("R1 clamp_pos", {11'b0, clamp_pos}, {11'b0, !m_busy});
            check("R4 aux_pos", {11'b0, aux_pos},
                  {11'b0, m_busy && m_k >= 2 && m_k <= 1 + T0 + TZ});
            check("R7 clamp_neg", {11'b0, clamp_neg}, {11'b0, !(m_busy && m_k >= 1 + A)});
            check("R7 aux_neg", {11'b0, aux_neg},
                  {11'b0, m_busy && m_k >= 2 + A && m_k <= 1 + T0 + TZ});
            check("R5 main_pat", main_pat, m_applied);
            check("R9 exclusion", {11'b0, (clamp_pos & aux_pos) | (clamp_neg & aux_neg)}, '0);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R2: rest state after reset
        check("R2 reset clamps", {10'b0, clamp_pos, clamp_neg}, 12'h3);
        check("R2 reset aux", {10'b0, aux_pos, aux_neg}, 12'h0);
        check("R2 reset main", main_pat, 12'h000);
        wait_n(5);
        check("R2 equal pattern no start", {11'b0, clamp_pos}, 12'h1);

        // First commutation
        pat_in = 12'h0A5;
        wait_n(1);
        check("R1 clamp_pos opens", {11'b0, clamp_pos}, 12'h0);
        check("R3 aux_pos still off", {11'b0, aux_pos}, 12'h0);
        check("R7 clamp_neg still on", {11'b0, clamp_neg}, 12'h1);
        wait_n(1);
        check("R3 aux_pos on at k2", {11'b0, aux_pos}, 12'h1);
        wait_n(T0 - 1);
        check("R5 old pattern before zero", main_pat, 12'h000);
        wait_n(1);
        check("R5 new pattern in zero", main_pat, 12'h0A5);
        wait_n(TZ);
        check("R6 recharge gates off", {9'b0, clamp_pos, aux_pos, clamp_neg, aux_neg}, 12'h0);
        wait_n(TR);
        check("R6 reclamped", {10'b0, clamp_pos, clamp_neg}, 12'h3);

        // R8: two changes during a cycle, latest pending wins
        wait_n(3);
        pat_in = 12'h111;
        wait_n(5);
        pat_in = 12'h222;
        wait_n(3);
        pat_in = 12'h333;
        wait_n(60);
        check("R8 pending latest applied", main_pat, 12'h333);
        check("R8 back at rest", {10'b0, clamp_pos, clamp_neg}, 12'h3);

        // R8: change back to target mid-cycle ends in the last pattern
        pat_in = 12'h444;
        wait_n(4);
        pat_in = 12'h555;
        wait_n(4);
        pat_in = 12'h444;
        wait_n(90);
        check("R8 final pattern", main_pat, 12'h444);

        // R10: reset in the middle of a sequence
        pat_in = 12'h7FF;
        wait_n(15);
        pat_in = 12'h123;
        rst = 1'b1;
        wait_n(1);
        rst = 1'b0;
        check("R10 main cleared", main_pat, 12'h000);
        check("R10 clamps on", {10'b0, clamp_pos, clamp_neg}, 12'h3);
        check("R10 aux off", {10'b0, aux_pos, aux_neg}, 12'h0);
        wait_n(40);
        check("R10 no stale pending", main_pat, 12'h123);
        wait_n(5);
        finish_run();
    end

endmodule